// File: doc/BRIEF.md
# Two-Wire Level-Encoded Serial Link with Per-Word Acknowledge

This block carries parallel words across a narrow channel of two wires plus one return wire. The transmitter accepts a word on a valid/ready stream and shifts it out most-significant bit first, one bit per clock. One wire always holds the present bit's value. The other wire, the parity companion, is adjusted so that exactly one of the pair changes for each bit. No spacer separates bits, so every bit costs exactly one wire edge.

The receiver spots a new bit when the XOR of the two wires differs from the value it last recorded. It shifts the bit into an assembly register and, after the last bit of the word, presents the word on a valid/ready output stream. When that word is taken, the receiver flips the acknowledge wire once. The transmitter brings the acknowledge into its own timing through a chain of synchronizing flops and opens its input for the next word only when it sees that flip. The one exception is the first word after reset, which needs no acknowledge. Back-pressure rules: `in_ready` is high only while the transmitter is idle, and a word is taken on a clock edge where `in_valid` and `in_ready` are both high. `out_valid` stays high, with `out_data` unchanged, until a clock edge where `out_ready` is high. A stalled output therefore stalls the whole link.

Top module: `ledr_serial_link`

## Requirements
- R1: During and after reset, `link_state`, `link_phase` and `link_ack` are 0, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` drops on the edge that takes a word. It stays low while that word is being sent, while it waits at the output, and until the matching acknowledge has been seen.
- R3: From the edge after a word is taken, `link_state` carries bit WIDTH-1 down to bit 0 of that word, one bit per clock, WIDTH consecutive clocks.
- R4: On each of those WIDTH clocks exactly one of `link_state` and `link_phase` changes, and neither changes on any other clock.
- R5: The clock after the last bit appears on the wires, `out_valid` rises with `out_data` equal to the sent word.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged. No bit arrives on the wires in that time.
- R7: `link_ack` toggles exactly once per output handshake, on the handshake edge, and never otherwise.
- R8: The first word after reset is accepted with no acknowledge having occurred.
- R9: The acknowledge reaches the transmitter through SYNC_STAGES flops, and `in_ready` rises exactly SYNC_STAGES+1 clocks after `link_ack` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word offered to the transmitter |
| in_ready | output | 1 | Transmitter idle and able to take a word |
| in_data | input | WIDTH | Word to send |
| out_valid | output | 1 | Rebuilt word available |
| out_ready | input | 1 | Consumer accepts the rebuilt word |
| out_data | output | WIDTH | Rebuilt word |
| link_state | output | 1 | Bit-value wire of the pair |
| link_phase | output | 1 | Parity companion wire of the pair |
| link_ack | output | 1 | Per-word acknowledge, toggling |

## Verification
Suppose the transmitter chose the companion wire wrongly. On the very clock of that bit, the wires would show either two edges or none. The receiver would then miss or double a bit, and the next rebuilt word would come out shifted or too late. If the receiver's parity reference drifted, `out_valid` would fail to rise exactly one clock after the last bit, or `link_ack` would flip without a handshake. A lost or stale acknowledge in the transmitter would show as `in_ready` returning at the wrong distance from the `link_ack` edge, or never returning. Every one of these shows at the ports within a single word time.

// File: rtl/ledr_link_pkg.sv
package ledr_link_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_e;

  // Companion wire value that makes exactly one of the pair move for a bit.
  function automatic logic companion_next(input logic bit_v, input logic cur_s,
                                          input logic cur_p);
    return (bit_v == cur_s) ? ~cur_p : cur_p;
  endfunction

endpackage

// File: rtl/ledr_sync.sv
module ledr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ledr_tx.sv
module ledr_tx
  import ledr_link_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             wire_s,
  output logic             wire_p,
  input  logic             ack_async
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  tx_state_e        st;
  logic [WIDTH-1:0] shreg;
  logic [CW-1:0]    bitcnt;
  logic             ack_local;
  logic             ack_ref;
  logic             cur_bit;

  ledr_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ack_async),
    .q    (ack_local)
  );

  assign in_ready = (st == TX_IDLE);
  assign cur_bit  = shreg[WIDTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= TX_IDLE;
      shreg   <= '0;
      bitcnt  <= '0;
      wire_s  <= 1'b0;
      wire_p  <= 1'b0;
      ack_ref <= 1'b0;
    end else begin
      unique case (st)
        TX_IDLE: begin
          if (in_valid) begin
            shreg  <= in_data;
            bitcnt <= '0;
            st     <= TX_SEND;
          end
        end
        TX_SEND: begin
          wire_s <= cur_bit;
          wire_p <= companion_next(cur_bit, wire_s, wire_p);
          shreg  <= shreg << 1;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST) st <= TX_WAIT;
        end
        TX_WAIT: begin
          if (ack_local != ack_ref) begin
            ack_ref <= ack_local;
            st      <= TX_IDLE;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ledr_rx.sv
module ledr_rx #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wire_s,
  input  logic             wire_p,
  output logic             ack,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic             par_ref;
  logic             par_now;
  logic             new_bit;
  logic [WIDTH-1:0] accum;
  logic [CW-1:0]    bitcnt;

  assign par_now = wire_s ^ wire_p;
  assign new_bit = (par_now != par_ref);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_ref   <= 1'b0;
      accum     <= '0;
      bitcnt    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      ack       <= 1'b0;
    end else begin
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        ack       <= ~ack;
      end
      if (new_bit) begin
        par_ref <= par_now;
        accum   <= {accum[WIDTH-2:0], wire_s};
        if (bitcnt == LAST) begin
          bitcnt    <= '0;
          out_valid <= 1'b1;
          out_data  <= {accum[WIDTH-2:0], wire_s};
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ledr_serial_link.sv
module ledr_serial_link #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             link_state,
  output logic             link_phase,
  output logic             link_ack
);
  ledr_tx #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .wire_s   (link_state),
    .wire_p   (link_phase),
    .ack_async(link_ack)
  );

  ledr_rx #(.WIDTH(WIDTH)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .wire_s   (link_state),
    .wire_p   (link_phase),
    .ack      (link_ack),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );
endmodule

// File: rtl/ledr_serial_link_chk.sv
module ledr_serial_link_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data,
  input logic             link_state,
  input logic             link_phase,
  input logic             link_ack
);
  AST_ONE_WIRE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({link_state, link_phase} ^ $past({link_state, link_phase})) <= 1); // R4

  AST_IDLE_WIRES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> $stable({link_state, link_phase})); // R4

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

  AST_NO_BIT_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(link_state ^ link_phase)); // R6

  AST_ACK_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_ack) |-> $past(out_valid && out_ready)); // R7

  AST_HANDSHAKE_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !$stable(link_ack)); // R7

  AST_BUSY_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R2
endmodule

bind ledr_serial_link ledr_serial_link_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .link_state(link_state),
  .link_phase(link_phase),
  .link_ack  (link_ack)
);

// File: tb/test_ledr_serial_link.sv
module test_ledr_serial_link;
  localparam int W    = 8;
  localparam int SYNC = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;
  logic         link_state, link_phase, link_ack;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int stall_mode = 0;
  int words_sent = 0;
  int ack_edges = 0;
  int ack_cyc = -1;
  logic [W-1:0] wq[$];
  logic         bq[$];
  logic [1:0]   prev_sp = 2'b00;
  logic         prev_ack = 1'b0;
  logic         prev_rdy = 1'b1;

  always #4 clk = ~clk;

  ledr_serial_link #(.WIDTH(W), .SYNC_STAGES(SYNC)) i_ledr_serial_link (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .link_state(link_state), .link_phase(link_phase),
    .link_ack(link_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic send_word(input logic [W-1:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wq.push_back(w);
    for (int i = W - 1; i >= 0; i--) bq.push_back(w[i]);
    words_sent++;
  endtask

  // out_ready pattern: 0 always ready, 1 periodic, 2 held low
  always @(negedge clk) begin
    cyc++;
    case (stall_mode)
      1:       out_ready = (cyc % 5 == 0);
      2:       out_ready = 1'b0;
      default: out_ready = 1'b1;
    endcase
  end

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if ({link_state, link_phase} != prev_sp) begin
        chk($countones({link_state, link_phase} ^ prev_sp) == 1, "R4 one wire per bit",
            $countones({link_state, link_phase} ^ prev_sp), 1);
        if (bq.size() == 0) chk(1'b0, "R3 unexpected bit", link_state, 0);
        else begin
          logic eb;
          eb = bq.pop_front();
          chk(link_state == eb, "R3 state wire bit", link_state, eb);
        end
      end
      if (link_ack != prev_ack) begin
        ack_edges++;
        ack_cyc = cyc;
      end
      if (in_ready && !prev_rdy) begin
        chk(ack_cyc >= 0 && (cyc - ack_cyc) == SYNC + 1, "R9 ready after ack",
            cyc - ack_cyc, SYNC + 1);
      end
      if (wq.size() != 0) chk(!in_ready, "R2 ready while word in flight", in_ready, 0);
      if (out_valid) begin
        if (wq.size() == 0) chk(1'b0, "R5 unexpected word", out_data, 0);
        else if (out_ready) begin
          logic [W-1:0] ew;
          ew = wq.pop_front();
          chk(bq.size() == 0, "R5 word before last bit", bq.size(), 0);
          chk(out_data == ew, "R5 word data", out_data, ew);
        end else begin
          chk(out_data == wq[0], "R6 held word", out_data, wq[0]);
        end
      end
      prev_sp  = {link_state, link_phase};
      prev_ack = link_ack;
      prev_rdy = in_ready;
    end
  end

  task automatic drain();
    int n = 0;
    while ((wq.size() != 0 || !in_ready) && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_tests();
    logic [W-1:0] lfsr = 8'hC3;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(link_state == 0 && link_phase == 0, "R1 wires", {link_state, link_phase}, 0);
    chk(link_ack == 0, "R1 ack", link_ack, 0);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: first word needs no acknowledge
    chk(in_ready == 1 && ack_edges == 0, "R8 first word ready", in_ready, 1);
    send_word(8'h00);
    send_word(8'hFF);
    send_word(8'hA5);
    send_word(8'h5A);
    send_word(8'h80);
    send_word(8'h01);
    drain();
    // periodic back-pressure, R6
    stall_mode = 1;
    for (int k = 0; k < 6; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      send_word(lfsr);
    end
    drain();
    // long stall: link must freeze, R2/R6
    stall_mode = 2;
    send_word(8'h3C);
    while (!out_valid) @(negedge clk);
    repeat (30) @(negedge clk);
    #1;
    chk(out_valid == 1, "R6 valid held", out_valid, 1);
    chk(in_ready == 0, "R2 blocked during stall", in_ready, 0);
    chk(ack_edges == words_sent - 1, "R7 no ack during stall", ack_edges, words_sent - 1);
    stall_mode = 0;
    send_word(8'h96);
    drain();
    repeat (5) @(negedge clk);
    #2;
    chk(ack_edges == words_sent, "R7 one ack per word", ack_edges, words_sent);
    chk(wq.size() == 0 && bq.size() == 0, "R5 all words delivered", wq.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule